// File: doc/BRIEF.md
# Backlight PWM generator

This block drives a panel backlight with a pulse-width-modulated enable. Timing is counted in ticks of a slow reference of roughly 32 kHz, which arrives as a one-cycle enable pulse (`tick_i`) in the system clock domain. One period spans twice the programmed divider in reference ticks. The output is high at the start of each period for a duty fraction counted in sixteenths.

All settings live in one 32-bit configuration word. A 4-bit duty code sits at bits 31:28 and a 10-bit divider at bits 25:16. Bits 15:0 hold a display line length in bytes, which is twice the horizontal pixel count for a 16-bit-per-pixel format. The block only keeps the line length so software can read it back; the waveform never uses it. The word is written through a single write strobe and is always visible on the read port.

Settings written in the middle of a period take effect at the next period boundary, so the output never produces a shortened pulse. Sequencing is a three-state machine:
- `ST_OFF`: output low, no period running.
- `ST_ON`: output high.
- `ST_REST`: output low for the rest of the period.

On any reference tick, `ST_OFF` starts a period. At the start of a period the machine enters:
- `ST_ON` when the high time is nonzero.
- `ST_REST` when the duty and divider are both nonzero but the high time rounds down to zero.
- `ST_OFF` when the duty or the divider is zero.

While a period runs, `ST_ON` moves to `ST_REST` on the tick where the high time is used up. On the last tick of the period, `ST_ON` or `ST_REST` begins a new period.

Top module: `blpwm_top`

## Requirements
- R1: A write stores the duty code in bits 31:28, the divider in bits 25:16 and the line length in bits 15:0, and the read port returns them at those positions from the cycle after the write.
- R2: Bits 27:26 of the configuration word ignore writes and always read as zero.
- R3: One output period lasts exactly 2×divider reference ticks, and the output and period position change only on clock edges where `tick_i` is high.
- R4: Within each period the output is high for the first floor(2×divider×duty/16) ticks and low for the remainder.
- R5: A duty code of 8 gives an output that is high for exactly half of each period.
- R6: When the divider or the duty code is zero, the output stays low.
- R7: A configuration written during a running period does not change the waveform until that period ends. The next period uses the new values.
- R8: Reset clears the whole configuration word to zero and drives the output low.
- R9: The line-length field has no effect on the output waveform.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Write strobe for the configuration word |
| wr_data_i | input | 32 | Configuration word to store |
| rd_data_o | output | 32 | Stored configuration word |
| tick_i | input | 1 | One-cycle enable per reference tick |
| pwm_o | output | 1 | Backlight enable waveform |

## Verification
The bench builds the block with its default 10-bit divider and 4-bit duty code. These defaults let small dividers (1, 2, 3, 7) show the rounding of the high time down to zero and one tick. The 1-kHz setting of 16 confirms the half-duty point. The largest divider, 1023, gives a 2046-tick period and checks that the high-time product does not overflow. A change written part-way through a period shows the boundary hand-over, and the same duty and divider with two different line lengths shows that the line length does not reach the waveform.

// File: rtl/blpwm_pkg.sv
package blpwm_pkg;
    localparam int CFG_W    = 32;
    localparam int DUTY_W   = 4;
    localparam int DUTY_LSB = CFG_W - DUTY_W;
    localparam int DIV_LSB  = 16;
    localparam int PITCH_W  = 16;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_ON   = 2'd1,
        ST_REST = 2'd2
    } pwm_state_e;

    // Mask of the bits a write may change for a divider of the given width.
    function automatic logic [CFG_W-1:0] keep_mask(input int div_w);
        logic [CFG_W-1:0] m;
        for (int i = 0; i < CFG_W; i++) begin
            m[i] = !((i >= DIV_LSB + div_w) && (i < DUTY_LSB));
        end
        return m;
    endfunction
endpackage

// File: rtl/blpwm_cfg_reg.sv
module blpwm_cfg_reg
    import blpwm_pkg::*;
#(
    parameter int DIV_W = 10
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic [CFG_W-1:0]  wr_data_i,
    output logic [CFG_W-1:0]  cfg_o,
    output logic [DUTY_W-1:0] duty_o,
    output logic [DIV_W-1:0]  div_o
);
    localparam logic [CFG_W-1:0] KEEP = keep_mask(DIV_W);

    logic [CFG_W-1:0] cfg_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cfg_q <= '0;
        end else if (wr_en_i) begin
            cfg_q <= wr_data_i & KEEP;
        end
    end

    always_comb begin
        cfg_o  = cfg_q;
        duty_o = cfg_q[DUTY_LSB +: DUTY_W];
        div_o  = cfg_q[DIV_LSB +: DIV_W];
    end

    // Bits between the divider and the duty code must never hold a one.
    assert_rsv_zero_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (cfg_o & ~KEEP) == '0)
        else $error("reserved configuration bits set");
endmodule

// File: rtl/blpwm_span.sv
module blpwm_span
    import blpwm_pkg::*;
#(
    parameter int DIV_W = 10
) (
    input  logic [DUTY_W-1:0] duty_i,
    input  logic [DIV_W-1:0]  div_i,
    output logic [DIV_W:0]    last_o,
    output logic [DIV_W:0]    high_o,
    output logic              live_o
);
    localparam int PER_W  = DIV_W + 1;
    localparam int PROD_W = PER_W + DUTY_W;

    logic [PER_W-1:0]  period;
    logic [PROD_W-1:0] prod;

    always_comb begin
        period = {div_i, 1'b0};
        last_o = period - PER_W'(1);
        prod   = PROD_W'(period) * PROD_W'(duty_i);
        high_o = prod[PROD_W-1:DUTY_W];
        live_o = (div_i != '0) && (duty_i != '0);
    end
endmodule

// File: rtl/blpwm_seq.sv
module blpwm_seq
    import blpwm_pkg::*;
#(
    parameter int DIV_W = 10
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              tick_i,
    input  logic [DUTY_W-1:0] new_duty_i,
    input  logic [DIV_W-1:0]  new_div_i,
    output logic              pwm_o
);
    localparam int CNT_W = DIV_W + 1;

    pwm_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_inc;
    logic [DUTY_W-1:0] act_duty_q;
    logic [DIV_W-1:0]  act_div_q;
    logic              load;
    pwm_state_e        start_state;

    logic [CNT_W-1:0] span_last [2];
    logic [CNT_W-1:0] span_high [2];
    logic             span_live [2];
    logic [DUTY_W-1:0] span_duty [2];
    logic [DIV_W-1:0]  span_div  [2];

    assign span_duty[0] = act_duty_q;
    assign span_div[0]  = act_div_q;
    assign span_duty[1] = new_duty_i;
    assign span_div[1]  = new_div_i;

    // Index 0 measures the running period, index 1 the pending settings.
    for (genvar g = 0; g < 2; g++) begin : g_span
        blpwm_span #(.DIV_W(DIV_W)) span_i (
            .duty_i (span_duty[g]),
            .div_i  (span_div[g]),
            .last_o (span_last[g]),
            .high_o (span_high[g]),
            .live_o (span_live[g])
        );
    end

    always_comb begin
        if (!span_live[1])            start_state = ST_OFF;
        else if (span_high[1] == '0)  start_state = ST_REST;
        else                          start_state = ST_ON;
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        cnt_inc = cnt_q + CNT_W'(1);
        load    = 1'b0;
        if (tick_i) begin
            unique case (state_q)
                ST_OFF: begin
                    load    = 1'b1;
                    cnt_d   = '0;
                    state_d = start_state;
                end
                ST_ON, ST_REST: begin
                    if (cnt_q == span_last[0]) begin
                        load    = 1'b1;
                        cnt_d   = '0;
                        state_d = start_state;
                    end else begin
                        cnt_d = cnt_inc;
                        if (state_q == ST_ON && cnt_inc == span_high[0]) begin
                            state_d = ST_REST;
                        end
                    end
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q    <= ST_OFF;
            cnt_q      <= '0;
            act_duty_q <= '0;
            act_div_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (load) begin
                act_duty_q <= new_duty_i;
                act_div_q  <= new_div_i;
            end
        end
    end

    always_comb begin
        pwm_o = (state_q == ST_ON);
    end

    // Nothing moves between reference ticks.
    assert_tick_gate_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        !tick_i |=> ($stable(pwm_o) && $stable(cnt_q)))
        else $error("period advanced without a tick");

    // High only inside the leading part of the period.
    assert_high_window_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        pwm_o |-> (cnt_q < span_high[0]))
        else $error("output high past its high time");

    // Zero divider or zero duty never lights the output.
    assert_dark_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (act_div_q == '0 || act_duty_q == '0) |-> !pwm_o)
        else $error("output high with zero setting");

    // Running settings hold until the period ends.
    assert_hold_cfg_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q != ST_OFF && cnt_q != span_last[0])
            |=> ($stable(act_div_q) && $stable(act_duty_q)))
        else $error("settings changed mid-period");
endmodule

// File: rtl/blpwm_top.sv
module blpwm_top
    import blpwm_pkg::*;
#(
    parameter int DIV_W = 10
) (
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        wr_en_i,
    input  logic [31:0] wr_data_i,
    output logic [31:0] rd_data_o,
    input  logic        tick_i,
    output logic        pwm_o
);
    logic [DUTY_W-1:0] duty;
    logic [DIV_W-1:0]  div;

    blpwm_cfg_reg #(.DIV_W(DIV_W)) cfg_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .cfg_o     (rd_data_o),
        .duty_o    (duty),
        .div_o     (div)
    );

    blpwm_seq #(.DIV_W(DIV_W)) seq_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .tick_i     (tick_i),
        .new_duty_i (duty),
        .new_div_i  (div),
        .pwm_o      (pwm_o)
    );
endmodule

// File: tb/blpwm_top_tb_top.sv
module blpwm_top_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic        tick;
    logic        pwm;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    blpwm_top dut_i (
        .clk_i     (clk),
        .rst_i     (rst),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .rd_data_o (rd_data),
        .tick_i    (tick),
        .pwm_o     (pwm)
    );

    localparam int NVEC = 9;
    localparam logic [31:0] VEC [NVEC] = '{
        32'h8010_01E0,  // duty 8, div 16: 1 kHz half duty (R5)
        32'h8010_0500,  // same timing, other pitch (R9)
        32'h4003_0000,  // period 6, high 1
        32'hF002_0000,  // period 4, high 3
        32'h1001_0000,  // period 2, high rounds to 0
        32'h0005_1234,  // duty 0 (R6)
        32'hC000_00F0,  // divider 0 (R6)
        32'h2007_0000,  // period 14, high 1
        32'hF3FF_0000   // divider 1023, period 2046
    };

    function automatic bit exp_bit(input logic [31:0] c, input int i);
        int dv = int'(c[25:16]);
        int dt = int'(c[31:28]);
        int p  = 2 * dv;
        int hl;
        if (dv == 0 || dt == 0) return 1'b0;
        hl = (p * dt) / 16;
        return ((i - 1) % p) < hl;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; tick = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic write_cfg(input logic [31:0] w);
        @(negedge clk);
        wr_en = 1'b1; wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // One tick pulse; output sampled at the negedge after the capturing edge.
    task automatic tick_once();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        #1_400_000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_data = '0; tick = 1'b0;
        do_reset();
        // R8: reset state
        check(rd_data == 32'h0 && pwm == 1'b0, "R8", "reset state",
              {rd_data[30:0], pwm}, 32'h0);

        // Table walk: R1 readback plus R3/R4/R5/R6/R9 waveform per tick.
        for (int v = 0; v < NVEC; v++) begin
            int per;
            int n;
            int bad_i;
            bit ok;
            logic got;
            do_reset();
            write_cfg(VEC[v]);
            check(rd_data == VEC[v], "R1", "readback", rd_data, VEC[v]);
            per = 2 * int'(VEC[v][25:16]);
            n   = (per == 0) ? 40 : 2 * per + 3;
            ok  = 1'b1; bad_i = 0; got = 1'b0;
            for (int i = 1; i <= n; i++) begin
                tick_once();
                if (ok && pwm !== exp_bit(VEC[v], i)) begin
                    ok = 1'b0; bad_i = i; got = pwm;
                end
            end
            check(ok, "R4", $sformatf("vector %0d tick %0d", v, bad_i),
                  {31'd0, got}, {31'd0, exp_bit(VEC[v], bad_i)});
        end

        // R2: reserved bits drop writes.
        do_reset();
        write_cfg(32'hFFFF_FFFF);
        check(rd_data == 32'hF3FF_FFFF, "R2", "reserved bits", rd_data, 32'hF3FF_FFFF);

        // R3: no movement without ticks (period 4, high 3, enter high).
        do_reset();
        write_cfg(32'hF002_0000);
        tick_once();
        begin
            bit stable = 1'b1;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (pwm !== 1'b1) stable = 1'b0;
            end
            check(stable, "R3", "hold between ticks", {31'd0, pwm}, 32'd1);
        end
        tick_once(); tick_once();
        tick_once();
        check(pwm == 1'b0, "R3", "high time ends after third tick", {31'd0, pwm}, 32'd0);

        // R7: change mid-period; old period finishes, new applies at tick 9.
        do_reset();
        write_cfg(32'h8004_0000);       // period 8, high 4
        begin
            bit ok = 1'b1;
            int bad_i = 0;
            logic e;
            for (int i = 1; i <= 20; i++) begin
                if (i == 4) write_cfg(32'hF002_0000);  // period 4, high 3
                tick_once();
                e = (i <= 8) ? exp_bit(32'h8004_0000, i) : exp_bit(32'hF002_0000, i - 8);
                if (ok && pwm !== e) begin ok = 1'b0; bad_i = i; end
            end
            check(ok, "R7", $sformatf("boundary hand-over tick %0d", bad_i),
                  {31'd0, pwm}, 32'd0);
        end

        // R6: divider cleared during a period lowers output from next period.
        do_reset();
        write_cfg(32'h8002_0000);       // period 4, high 2
        tick_once();
        write_cfg(32'h8000_0000);
        tick_once(); tick_once(); tick_once();
        tick_once();
        check(pwm == 1'b0, "R6", "zero divider after boundary", {31'd0, pwm}, 32'd0);

        // R8: reset while output high.
        do_reset();
        write_cfg(32'hF010_0040);
        tick_once();
        check(pwm == 1'b1, "R4", "first tick high", {31'd0, pwm}, 32'd1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check(pwm == 1'b0 && rd_data == 32'h0, "R8", "reset mid-pulse",
              {rd_data[30:0], pwm}, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        done = 1'b1;
        $finish;
    end
endmodule